// File: doc/BRIEF.md
# Sprite Scanline Compositing Engine

This block keeps a table of sprite descriptors and draws the sprites one scanline ahead of the display. A host processor reads and writes the descriptor table through its own port at any time. The engine reads the table through a second port, so host writes never hold up drawing. Each descriptor is a packed 32-bit word. It gives the sprite's screen position, the base address of its pixel data, its size (16 or 32 pixels square), a horizontal mirror bit and an enable bit.

A pulse on `lineStart` swaps the two line buffers and gives the engine the number of the line to draw next. The engine first clears the buffer it now owns. It then walks all descriptors in index order and picks each enabled sprite whose vertical span covers that line. For each picked sprite it fetches one pixel row, a 32-bit word (two 16-bit pixels) at a time, over a request/acknowledge read port. Opaque pixels are written into the buffer at the sprite's X offset. Meanwhile the other buffer is read out pixel by pixel for the line on screen.

The engine draws at most a fixed number of sprite pixels per line. When the next picked sprite would go past that limit, drawing stops for the line and a sticky overflow flag is raised.

Top module: `sprite_compositor`

## Requirements
- R1: Descriptor `d` at CPU address `a` is written when `cpuEn` and `cpuWe` are both high. With `cpuEn` high and `cpuWe` low, `cpuRdata` shows the stored word one cycle later. Field layout: bits 9:0 X, bits 18:10 Y, bits 27:19 row pointer base, bit 28 size (0 = 16 px, 1 = 32 px), bit 29 horizontal mirror, bit 31 enable.
- R2: A sprite is drawn on line L only if bit 31 is set and (L − Y) mod 512 is less than its height. The height equals the width (16 or 32). This includes sprites that wrap past line 511.
- R3: Row r of a sprite is read from word addresses pointer base + r·W/2 onward, where W is the sprite width. The low half of each word is the left pixel of the pair. `memAddr` holds steady while `memReq` waits for `memAck`.
- R4: Row pixel p goes to screen column X + p. Columns at or beyond 640 are not written.
- R5: When the mirror bit is set, row pixel p goes to column X + W − 1 − p.
- R6: A pixel value of 0x0000 is transparent and leaves the buffer entry unchanged.
- R7: Where sprites overlap, the higher-numbered descriptor's opaque pixel wins.
- R8: A `lineStart` pulse swaps the buffers. `pixOut` shows the shown buffer's entry at `pixX` one cycle after `pixX` is applied. The shown buffer holds the line given at the previous pulse.
- R9: Every line starts from a fully transparent buffer. No pixel from an earlier line remains.
- R10: At most 640 sprite pixels (a sum of sprite widths) are drawn per line. A sprite that would go past this limit ends drawing for that line and sets `budgetOvf`, which stays set until reset.
- R11: After reset, `memReq` and `budgetOvf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuEn | input | 1 | CPU access strobe |
| cpuWe | input | 1 | CPU write (1) or read (0) |
| cpuAddr | input | 9 | Descriptor index |
| cpuWdata | input | 32 | Descriptor write data |
| cpuRdata | output | 32 | Descriptor read data, one cycle latency |
| lineStart | input | 1 | Swap buffers and begin drawing the next line |
| renderLine | input | 9 | Line number to draw, sampled with lineStart |
| memReq | output | 1 | Pixel word request |
| memAddr | output | 16 | Pixel word address |
| memAck | input | 1 | Word present on memData this cycle |
| memData | input | 32 | Two pixels, left pixel in the low half |
| pixX | input | 10 | Display read column |
| pixOut | output | 16 | Display pixel, registered |
| budgetOvf | output | 1 | Sticky per-line pixel budget overflow |

## Verification
Directed lines place a plain sprite, a mirrored 32-pixel sprite over it, a sprite that runs off the right edge, a disabled sprite and a sprite that wraps from line 500. Together these separate placement, mirroring, clipping, priority and modulo selection. A line with no sprites, drawn after busy lines, shows whether stale pixels survive the buffer swap. Random tables over random lines, with a memory that acknowledges on random cycles, check address sequencing and transparency across many layouts. Exactly 20 wide sprites on one line followed by a 21st tell apart a budget that is met from one that is exceeded.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int XW = 11;

  typedef struct packed {
    logic          swap;
    logic          clrEn;
    logic [XW-1:0] clrIdx;
    logic          pixWr;
    logic [31:0]   pixWord;
    logic [XW-1:0] baseX;
    logic [4:0]    firstCol;
    logic          flip;
    logic          wide;
  } strobe_t;
endpackage

// File: rtl/spr_desc_ram.sv
module spr_desc_ram #(
  parameter int NUM_SPR = 512,
  localparam int IDXW = $clog2(NUM_SPR)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuEn,
  input  logic            cpuWe,
  input  logic [IDXW-1:0] cpuAddr,
  input  logic [31:0]     cpuWdata,
  output logic [31:0]     cpuRdata,
  input  logic [IDXW-1:0] engAddr,
  output logic [31:0]     engRdata
);
  logic [31:0] table_q [NUM_SPR];

  always_ff @(posedge clk) begin
    if (cpuEn && cpuWe) table_q[cpuAddr] <= cpuWdata;
    engRdata <= table_q[engAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) cpuRdata <= '0;
    else if (cpuEn && !cpuWe) cpuRdata <= table_q[cpuAddr];
  end

  // R1: CPU read data changes only on a read
  p_cpu_rd_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuEn && !cpuWe) |=> $stable(cpuRdata));
endmodule

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int NUM_SPR    = 512,
  parameter int LINE_W     = 640,
  parameter int PIX_BUDGET = 640,
  parameter int ADDR_W     = 16,
  localparam int IDXW = $clog2(NUM_SPR),
  localparam int UW   = $clog2(PIX_BUDGET + 64)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [8:0]        renderLine,
  output logic [IDXW-1:0]   descAddr,
  input  logic [31:0]       descData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [31:0]       memData,
  output strobe_t           strb,
  output logic              budgetOvf
);
  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_RD, S_CHK, S_FETCH, S_DONE} state_t;
  state_t state;

  logic [IDXW-1:0]   scanIdx;
  logic [8:0]        curLine;
  logic [XW-1:0]     clrCnt;
  logic [UW-1:0]     usedPix;
  logic [ADDR_W-1:0] rowBase;
  logic [3:0]        wordIdx;
  logic              wideQ, flipQ;
  logic [9:0]        xPos;

  logic [8:0] dy;
  logic [5:0] hgt;
  logic       hit, overBudget, lastSpr;
  logic [3:0] lastWord;

  always_comb begin
    dy         = curLine - descData[18:10];
    hgt        = descData[28] ? 6'd32 : 6'd16;
    hit        = descData[31] && (dy < 9'(hgt));
    overBudget = ({1'b0, usedPix} + (UW+1)'(hgt)) > (UW+1)'(PIX_BUDGET);
    lastSpr    = (scanIdx == IDXW'(NUM_SPR - 1));
    lastWord   = wideQ ? 4'd15 : 4'd7;
  end

  assign descAddr = scanIdx;
  assign memReq   = (state == S_FETCH);
  assign memAddr  = rowBase + ADDR_W'(wordIdx);

  always_comb begin
    strb          = '0;
    strb.swap     = lineStart;
    strb.clrEn    = (state == S_CLEAR) && !lineStart;
    strb.clrIdx   = clrCnt;
    strb.pixWr    = (state == S_FETCH) && memAck && !lineStart;
    strb.pixWord  = memData;
    strb.baseX    = XW'(xPos);
    strb.firstCol = {wordIdx, 1'b0};
    strb.flip     = flipQ;
    strb.wide     = wideQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      scanIdx   <= '0;
      curLine   <= '0;
      clrCnt    <= '0;
      usedPix   <= '0;
      rowBase   <= '0;
      wordIdx   <= '0;
      wideQ     <= 1'b0;
      flipQ     <= 1'b0;
      xPos      <= '0;
      budgetOvf <= 1'b0;
    end else if (lineStart) begin
      state   <= S_CLEAR;
      clrCnt  <= '0;
      curLine <= renderLine;
      scanIdx <= '0;
      usedPix <= '0;
    end else begin
      case (state)
        S_CLEAR: begin
          if (clrCnt == XW'(LINE_W / 2 - 1)) state <= S_RD;
          else clrCnt <= clrCnt + 1'b1;
        end
        S_RD: state <= S_CHK;
        S_CHK: begin
          if (hit && overBudget) begin
            budgetOvf <= 1'b1;
            state     <= S_DONE;
          end else if (hit) begin
            usedPix <= usedPix + UW'(hgt);
            rowBase <= ADDR_W'(descData[27:19]) +
                       (ADDR_W'(dy) << (descData[28] ? 4 : 3));
            xPos    <= descData[9:0];
            flipQ   <= descData[29];
            wideQ   <= descData[28];
            wordIdx <= '0;
            state   <= S_FETCH;
          end else if (lastSpr) begin
            state <= S_DONE;
          end else begin
            scanIdx <= scanIdx + 1'b1;
            state   <= S_RD;
          end
        end
        S_FETCH: begin
          if (memAck) begin
            if (wordIdx != lastWord) wordIdx <= wordIdx + 1'b1;
            else if (lastSpr) state <= S_DONE;
            else begin
              scanIdx <= scanIdx + 1'b1;
              state   <= S_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10: pixel budget never exceeded
  p_budget_r10: assert property (@(posedge clk) disable iff (!rstN)
    usedPix <= UW'(PIX_BUDGET));
  // R10: overflow flag is sticky
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    budgetOvf |=> budgetOvf);
  // R3: address held while request waits
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !lineStart) |=> (memReq && $stable(memAddr)));
endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
#(
  parameter int LINE_W = 640,
  localparam int XB = $clog2(LINE_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [XB-1:0] pixX,
  output logic [15:0]   pixOut
);
  logic [15:0] lineMem [2][LINE_W];
  logic        frontSel;
  logic        backSel;
  logic [XW-1:0] wrX  [2];
  logic          wrOk [2];
  logic [XB-1:0] clrBase;

  assign backSel = ~frontSel;
  assign clrBase = XB'(strb.clrIdx) << 1;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      logic [4:0] p, col;
      p = strb.firstCol + 5'(k);
      if (strb.flip) col = (strb.wide ? 5'd31 : 5'd15) - p;
      else col = p;
      wrX[k]  = strb.baseX + XW'(col);
      wrOk[k] = strb.pixWr && (strb.pixWord[16*k +: 16] != 16'h0000) &&
                (wrX[k] < XW'(LINE_W));
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clrEn) begin
      lineMem[backSel][clrBase]        <= 16'h0000;
      lineMem[backSel][clrBase + 1'b1] <= 16'h0000;
    end
    for (int k = 0; k < 2; k++) begin
      if (wrOk[k]) lineMem[backSel][wrX[k][XB-1:0]] <= strb.pixWord[16*k +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frontSel <= 1'b0;
      pixOut   <= 16'h0000;
    end else begin
      if (strb.swap) frontSel <= ~frontSel;
      pixOut <= ({1'b0, pixX} < (XB+1)'(LINE_W)) ? lineMem[frontSel][pixX] : 16'h0000;
    end
  end

  // R8: no buffer writes in the swap cycle
  p_swap_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.swap |-> !(strb.clrEn || strb.pixWr));
  // R9: clearing and drawing never overlap
  p_clear_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn |-> !strb.pixWr);
endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor
  import spr_pkg::*;
#(
  parameter int NUM_SPR    = 512,
  parameter int LINE_W     = 640,
  parameter int PIX_BUDGET = 640,
  parameter int ADDR_W     = 16,
  localparam int IDXW = $clog2(NUM_SPR),
  localparam int XB   = $clog2(LINE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuEn,
  input  logic              cpuWe,
  input  logic [IDXW-1:0]   cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  input  logic              lineStart,
  input  logic [8:0]        renderLine,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [31:0]       memData,
  input  logic [XB-1:0]     pixX,
  output logic [15:0]       pixOut,
  output logic              budgetOvf
);
  logic [IDXW-1:0] descAddr;
  logic [31:0]     descData;
  strobe_t         strb;

  spr_desc_ram #(.NUM_SPR(NUM_SPR)) u_ram (
    .clk(clk), .rstN(rstN), .cpuEn(cpuEn), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .engAddr(descAddr), .engRdata(descData)
  );

  spr_ctrl #(.NUM_SPR(NUM_SPR), .LINE_W(LINE_W), .PIX_BUDGET(PIX_BUDGET), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .renderLine(renderLine),
    .descAddr(descAddr), .descData(descData), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .strb(strb), .budgetOvf(budgetOvf)
  );

  spr_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixX(pixX), .pixOut(pixOut)
  );
endmodule

// File: tb/sprite_compositor_tb.sv
module sprite_compositor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RENDER_CYC = 3000;
  localparam int WATCHDOG   = 190000;

  logic clk = 0, rstN = 0;
  logic cpuEn = 0, cpuWe = 0;
  logic [8:0] cpuAddr = 0;
  logic [31:0] cpuWdata = 0, cpuRdata;
  logic lineStart = 0;
  logic [8:0] renderLine = 0;
  logic memReq, memAck = 0;
  logic [15:0] memAddr;
  logic [31:0] memData = 0;
  logic [9:0] pixX = 0;
  logic [15:0] pixOut;
  logic budgetOvf;

  int nChecks = 0, nFails = 0, cycles = 0;
  logic [31:0] tbl [512];
  logic [15:0] expPix [640];
  logic expOvf;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_compositor u_dut (
    .clk(clk), .rstN(rstN), .cpuEn(cpuEn), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .lineStart(lineStart),
    .renderLine(renderLine), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memData(memData), .pixX(pixX), .pixOut(pixOut), .budgetOvf(budgetOvf)
  );

  function automatic logic [31:0] memWord(input logic [15:0] a);
    logic [15:0] lo, hi;
    lo = (a % 7 == 3) ? 16'h0 : ((a * 16'd40503 + 16'd1) | 16'h0001);
    hi = (a % 5 == 1) ? 16'h0 : ((a * 16'd2654 + 16'd7) | 16'h8000);
    return {hi, lo};
  endfunction

  function automatic logic [31:0] mkDesc(input logic en, input logic flip, input logic wide,
      input logic [8:0] ptr, input logic [8:0] y, input logic [9:0] x);
    return {en, 1'b0, flip, wide, ptr, y, x};
  endfunction

  // memory model: random acknowledge, data from address
  always @(negedge clk) begin
    cycles++;
    memAck  <= memReq && ($urandom % 2 == 1);
    memData <= memWord(memAddr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input int idx, input logic [31:0] d);
    @(negedge clk);
    cpuEn = 1; cpuWe = 1; cpuAddr = 9'(idx); cpuWdata = d;
    @(negedge clk);
    cpuEn = 0; cpuWe = 0;
    tbl[idx] = d;
  endtask

  task automatic cpuReadCheck(input int idx);
    @(negedge clk);
    cpuEn = 1; cpuWe = 0; cpuAddr = 9'(idx);
    @(negedge clk);
    cpuEn = 0;
    check("R1 readback", cpuRdata, tbl[idx]);
  endtask

  // reference model of one line (R2..R7, R10)
  task automatic buildLine(input logic [8:0] L);
    int used;
    for (int x = 0; x < 640; x++) expPix[x] = 16'h0;
    used = 0;
    for (int i = 0; i < 512; i++) begin
      logic [8:0] dy;
      int h;
      dy = L - tbl[i][18:10];
      h = tbl[i][28] ? 32 : 16;
      if (tbl[i][31] && dy < 9'(h)) begin
        if (used + h > 640) begin expOvf = 1; break; end
        used += h;
        for (int p = 0; p < h; p++) begin
          logic [15:0] a, v;
          logic [31:0] w;
          int col, x;
          a = 16'(tbl[i][27:19]) + 16'(dy) * 16'(h / 2) + 16'(p / 2);
          w = memWord(a);
          v = (p % 2 == 1) ? w[31:16] : w[15:0];
          col = tbl[i][29] ? (h - 1 - p) : p;
          x = int'(tbl[i][9:0]) + col;
          if (v != 0 && x < 640) expPix[x] = v;
        end
      end
    end
  endtask

  task automatic pulse(input logic [8:0] L);
    @(negedge clk);
    lineStart = 1; renderLine = L;
    @(negedge clk);
    lineStart = 0;
  endtask

  task automatic runLine(input logic [8:0] L, input string req);
    buildLine(L);
    pulse(L);
    repeat (RENDER_CYC) @(negedge clk);
    pulse(L);                       // R8: line L now shown
    check({req, " R10 ovf"}, 32'(budgetOvf), 32'(expOvf));
    for (int x = 0; x < 640; x++) begin
      pixX = 10'(x);
      @(negedge clk);
      check($sformatf("%s line %0d px %0d", req, L, x), 32'(pixOut), 32'(expPix[x]));
    end
    repeat (RENDER_CYC) @(negedge clk);
  endtask

  initial begin
    cycles = 0;
    while (cycles < WATCHDOG) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    expOvf = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 memReq", 32'(memReq), 0);
    check("R11 budgetOvf", 32'(budgetOvf), 0);
    for (int i = 0; i < 512; i++) cpuWrite(i, 32'h0);
    // R1 random readback
    for (int n = 0; n < 8; n++) begin
      int idx = $urandom % 512;
      cpuWrite(idx, $urandom & 32'h7FFF_FFFF);
      cpuReadCheck(idx);
      cpuWrite(idx, 32'h0);
    end
    // directed layout
    cpuWrite(0, mkDesc(1, 0, 0, 9'd10, 9'd50, 10'd100));   // plain 16 px (R4)
    cpuWrite(1, mkDesc(1, 1, 1, 9'd200, 9'd40, 10'd108));  // mirrored 32 px over it (R5, R7)
    cpuWrite(2, mkDesc(1, 0, 1, 9'd300, 9'd45, 10'd630));  // clipped at right edge (R4)
    cpuWrite(3, mkDesc(0, 0, 1, 9'd77, 9'd50, 10'd300));   // disabled (R2)
    cpuWrite(4, mkDesc(1, 0, 1, 9'd400, 9'd500, 10'd20));  // wraps past 511 (R2)
    runLine(9'd50, "R4 R5 R6 R7");
    runLine(9'd5, "R2 wrap");
    runLine(9'd41, "R3 R5 rows");
    runLine(9'd100, "R9 empty");
    runLine(9'd100, "R9 empty again");
    // random tables
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 60; i++)
        cpuWrite(i, mkDesc($urandom % 4 != 0, 1'($urandom), 1'($urandom), 9'($urandom),
                           9'($urandom % 40), 10'($urandom % 660)));
      runLine(9'($urandom % 50), "R3 R6 random");
      runLine(9'($urandom % 50), "R3 R6 random");
    end
    // budget boundary (R10)
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    expOvf = 0;
    for (int i = 0; i < 60; i++) cpuWrite(i, 32'h0);
    for (int i = 0; i < 20; i++) cpuWrite(i, mkDesc(1, 0, 1, 9'(i), 9'd200, 10'(i * 32)));
    runLine(9'd210, "R10 exact budget");
    cpuWrite(20, mkDesc(1, 0, 1, 9'd99, 9'd200, 10'd5));
    runLine(9'd210, "R10 overflow");
    runLine(9'd300, "R10 sticky");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule